// File: doc/BRIEF.md
# Command Chaining Interrupt Status Queue

This block is the command-chaining front end of a token-passing network controller. It sits between a host processor and the transmit and receive engines of the controller. The host issues "send from page" and "receive into page" commands. Each kind can have up to two commands in flight, and each command keeps its page number. The block hands the commands to their engine one at a time and in the order they arrived. A stored second command starts as soon as the first one finishes.

Every completion becomes a queued event that carries its own success bit. The oldest transmit event and the oldest receive event are shown on the status outputs. The host retires them with separate clear strobes. Next to the queued events, level flags show the live state: transmitter available and receiver inhibited. A maskable interrupt line reports any unmasked event that is still queued.

A command holds its slot from the cycle it is accepted until the host clears its completion event. A command that arrives while both slots of its kind are held is dropped, and a sticky overflow flag is raised. The engines are modelled as a start pulse with a page, followed later by a done strobe that carries a success bit.

Top module: `cmd_chain_irq_q`

## Requirements
- R1: After reset, tx_avail_o and rx_inhib_o are 1. tx_evt_o, rx_evt_o, tx_ack_o, rx_ok_o, irq_o, ovf_o, tx_start_o and rx_start_o are all 0.
- R2: A command accepted at clock edge k drops tx_avail_o (or rx_inhib_o) to 0 after edge k. If the engine is idle, the command raises tx_start_o (or rx_start_o) for exactly one cycle after edge k+1, with the command's page on tx_page_o (or rx_page_o).
- R3: A second command is accepted while the first one is still running. After the done strobe for the first command is sampled at edge d, the second command's start pulse, with its own page, follows edge d+1. The host does not need to clear the first event for this to happen.
- R4: A done strobe sampled while the engine is busy queues an event. The event flag is 1 after that edge, and the event's success bit is the ok or ack value sampled with the done strobe. tx_avail_o (or rx_inhib_o) returns to 1 only when no command of that kind is waiting or running.
- R5: A clear strobe retires the oldest event of its kind. The next queued event then appears with its own success bit. A clear strobe with no event queued has no effect on the slot count.
- R6: Each kind has two slots. A command holds a slot until its event is cleared. A command that arrives while both slots are held is dropped and never started, and it sets ovf_o. Only reset clears ovf_o.
- R7: irq_o is 1 exactly when (tx_evt_o and tx_mask_i) or (rx_evt_o and rx_mask_i) is true. The masks have no effect on the event flags, the success bits or the live flags.
- R8: Transmit and receive commands, completions and clears can come in any order relative to each other, including in the same cycle. They act independently.
- R9: A done strobe while the engine is idle is ignored. It queues no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_cmd_i | input | 1 | Send command strobe |
| tx_page_i | input | PAGE_W | Buffer page for the send command |
| rx_cmd_i | input | 1 | Receive command strobe |
| rx_page_i | input | PAGE_W | Buffer page for the receive command |
| tx_clr_i | input | 1 | Retire the oldest transmit event |
| rx_clr_i | input | 1 | Retire the oldest receive event |
| tx_mask_i | input | 1 | Lets transmit events drive the interrupt |
| rx_mask_i | input | 1 | Lets receive events drive the interrupt |
| tx_start_o | output | 1 | One-cycle start pulse to the transmit engine |
| tx_page_o | output | PAGE_W | Page for the transmit engine |
| tx_done_i | input | 1 | Transmit engine finished |
| tx_ack_i | input | 1 | The finished packet was acknowledged |
| rx_start_o | output | 1 | One-cycle start pulse to the receive engine |
| rx_page_o | output | PAGE_W | Page for the receive engine |
| rx_done_i | input | 1 | Receive engine finished |
| rx_ok_i | input | 1 | The reception was good |
| tx_evt_o | output | 1 | A transmit completion event is queued |
| tx_ack_o | output | 1 | Success bit of the oldest transmit event, 0 when none is queued |
| tx_avail_o | output | 1 | No transmit command is waiting or running |
| rx_evt_o | output | 1 | A receive completion event is queued |
| rx_ok_o | output | 1 | Success bit of the oldest receive event, 0 when none is queued |
| rx_inhib_o | output | 1 | No receive command is waiting or running |
| ovf_o | output | 1 | Sticky flag: a command was dropped |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with SLOTS=2 and PAGE_W=8. With two slots, a full queue is only two commands away, so the bench can hold both slots with events the host has not yet cleared and then check that a third command is dropped. The 8-bit pages let every command carry its own page value, so a start pulse can be matched to the command that caused it. This shows that the chained command, and not a dropped one, reaches the engine. The same scenario table runs on both channels, each with its own mask setting, and an interleaved test finishes the two kinds out of order.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic {
    CH_TX = 1'b0,
    CH_RX = 1'b1
  } ch_e;
endpackage

// File: rtl/cc_irq.sv
module cc_irq #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  assign irq_o = |(evt_i & mask_i);
endmodule

// File: rtl/cc_chan.sv
module cc_chan #(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              done_i,
  input  logic              ok_i,
  input  logic              clr_i,
  output logic              start_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              evt_o,
  output logic              evt_ok_o,
  output logic              idle_o,
  output logic              ovf_o
);
  localparam int unsigned PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

  logic [PAGE_W-1:0] page_q [SLOTS];
  logic [SLOTS-1:0]  ok_q;
  logic [PTR_W-1:0]  wr_q, iss_q, rd_q;
  logic [CNT_W-1:0]  n_slot_q, n_cmd_q, n_evt;
  logic              busy_q, start_q, ovf_q;
  logic [PAGE_W-1:0] page_o_q;
  logic              accept, retire, launch, finish;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign n_evt  = n_slot_q - n_cmd_q;
  assign accept = cmd_i && (n_slot_q < FULL);
  assign retire = clr_i && (n_evt != '0);
  assign launch = !busy_q && (n_cmd_q != '0);
  assign finish = busy_q && done_i;

  // slot storage: page at accept, success bit at completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) page_q[i] <= '0;
      ok_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (accept && wr_q == PTR_W'(i)) page_q[i] <= page_i;
        if (finish && iss_q == PTR_W'(i)) ok_q[i] <= ok_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= '0;
      iss_q    <= '0;
      rd_q     <= '0;
      n_slot_q <= '0;
      n_cmd_q  <= '0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      page_o_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (accept) wr_q <= nxt(wr_q);
      if (cmd_i && !accept) ovf_q <= 1'b1;
      if (retire) rd_q <= nxt(rd_q);
      if (accept && !retire) n_slot_q <= n_slot_q + 1'b1;
      else if (!accept && retire) n_slot_q <= n_slot_q - 1'b1;
      if (accept && !finish) n_cmd_q <= n_cmd_q + 1'b1;
      else if (!accept && finish) n_cmd_q <= n_cmd_q - 1'b1;
      if (launch) begin
        busy_q   <= 1'b1;
        start_q  <= 1'b1;
        page_o_q <= page_q[iss_q];
      end
      if (finish) begin
        busy_q <= 1'b0;
        iss_q  <= nxt(iss_q);
      end
    end
  end

  assign start_o  = start_q;
  assign page_o   = page_o_q;
  assign evt_o    = (n_evt != '0);
  assign evt_ok_o = evt_o && ok_q[rd_q];
  assign idle_o   = (n_cmd_q == '0);
  assign ovf_o    = ovf_q;

  assert_slot_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_slot_q <= FULL) && (n_cmd_q <= n_slot_q));
  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_chain_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i && n_cmd_q > 1) |=> ##1 start_o);
  assert_evt_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> evt_o);
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && n_slot_q == FULL) |=> ovf_o);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  assert_clr_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_o && !cmd_i) |=> n_slot_q == $past(n_slot_q));
  assert_idle_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && done_i && !evt_o) |=> !evt_o);
endmodule

// File: rtl/cmd_chain_irq_q.sv
module cmd_chain_irq_q
  import cc_pkg::*;
#(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_cmd_i,
  input  logic [PAGE_W-1:0] tx_page_i,
  input  logic              rx_cmd_i,
  input  logic [PAGE_W-1:0] rx_page_i,
  input  logic              tx_clr_i,
  input  logic              rx_clr_i,
  input  logic              tx_mask_i,
  input  logic              rx_mask_i,
  output logic              tx_start_o,
  output logic [PAGE_W-1:0] tx_page_o,
  input  logic              tx_done_i,
  input  logic              tx_ack_i,
  output logic              rx_start_o,
  output logic [PAGE_W-1:0] rx_page_o,
  input  logic              rx_done_i,
  input  logic              rx_ok_i,
  output logic              tx_evt_o,
  output logic              tx_ack_o,
  output logic              tx_avail_o,
  output logic              rx_evt_o,
  output logic              rx_ok_o,
  output logic              rx_inhib_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] cmd_v, done_v, ok_v, clr_v, mask_v;
  logic [NUM_CH-1:0] start_v, evt_v, eok_v, idle_v, ovf_v;
  logic [PAGE_W-1:0] pin_a  [NUM_CH];
  logic [PAGE_W-1:0] pout_a [NUM_CH];

  // index CH_TX = 0, CH_RX = 1
  assign cmd_v  = {rx_cmd_i,  tx_cmd_i};
  assign done_v = {rx_done_i, tx_done_i};
  assign ok_v   = {rx_ok_i,   tx_ack_i};
  assign clr_v  = {rx_clr_i,  tx_clr_i};
  assign mask_v = {rx_mask_i, tx_mask_i};
  assign pin_a[CH_TX] = tx_page_i;
  assign pin_a[CH_RX] = rx_page_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cc_chan #(
      .SLOTS  (SLOTS),
      .PAGE_W (PAGE_W)
    ) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_i    (cmd_v[c]),
      .page_i   (pin_a[c]),
      .done_i   (done_v[c]),
      .ok_i     (ok_v[c]),
      .clr_i    (clr_v[c]),
      .start_o  (start_v[c]),
      .page_o   (pout_a[c]),
      .evt_o    (evt_v[c]),
      .evt_ok_o (eok_v[c]),
      .idle_o   (idle_v[c]),
      .ovf_o    (ovf_v[c])
    );
  end

  cc_irq #(.N(NUM_CH)) i_irq (
    .evt_i  (evt_v),
    .mask_i (mask_v),
    .irq_o  (irq_o)
  );

  assign tx_start_o = start_v[CH_TX];
  assign tx_page_o  = pout_a[CH_TX];
  assign rx_start_o = start_v[CH_RX];
  assign rx_page_o  = pout_a[CH_RX];
  assign tx_evt_o   = evt_v[CH_TX];
  assign tx_ack_o   = eok_v[CH_TX];
  assign tx_avail_o = idle_v[CH_TX];
  assign rx_evt_o   = evt_v[CH_RX];
  assign rx_ok_o    = eok_v[CH_RX];
  assign rx_inhib_o = idle_v[CH_RX];
  assign ovf_o      = |ovf_v;

  assert_irq_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_evt_o && tx_mask_i) |-> irq_o);
  assert_irq_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_evt_o && rx_mask_i) |-> irq_o);
  assert_irq_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_evt_o && !rx_evt_o) |-> !irq_o);
  assert_ack_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_evt_o |-> !tx_ack_o);
endmodule

// File: tb/test_cmd_chain_irq_q.sv
module test_cmd_chain_irq_q;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 8;

  typedef struct packed {
    logic [7:0] page;
    logic       ok;
    logic       mask;
    logic       exp_irq;
    logic       exp_ok;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'h12, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h34, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h56, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'h78, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hFF, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_cmd_i = 0, rx_cmd_i = 0, tx_clr_i = 0, rx_clr_i = 0;
  logic tx_mask_i = 0, rx_mask_i = 0, tx_done_i = 0, tx_ack_i = 0;
  logic rx_done_i = 0, rx_ok_i = 0;
  logic [PAGE_W-1:0] tx_page_i = '0, rx_page_i = '0;
  logic tx_start_o, rx_start_o, tx_evt_o, tx_ack_o, tx_avail_o;
  logic rx_evt_o, rx_ok_o, rx_inhib_o, ovf_o, irq_o;
  logic [PAGE_W-1:0] tx_page_o, rx_page_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_chain_irq_q #(.SLOTS(2), .PAGE_W(PAGE_W)) i_cmd_chain_irq_q (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_cmd_i(tx_cmd_i), .tx_page_i(tx_page_i),
    .rx_cmd_i(rx_cmd_i), .rx_page_i(rx_page_i),
    .tx_clr_i(tx_clr_i), .rx_clr_i(rx_clr_i),
    .tx_mask_i(tx_mask_i), .rx_mask_i(rx_mask_i),
    .tx_start_o(tx_start_o), .tx_page_o(tx_page_o),
    .tx_done_i(tx_done_i), .tx_ack_i(tx_ack_i),
    .rx_start_o(rx_start_o), .rx_page_o(rx_page_o),
    .rx_done_i(rx_done_i), .rx_ok_i(rx_ok_i),
    .tx_evt_o(tx_evt_o), .tx_ack_o(tx_ack_o), .tx_avail_o(tx_avail_o),
    .rx_evt_o(rx_evt_o), .rx_ok_o(rx_ok_o), .rx_inhib_o(rx_inhib_o),
    .ovf_o(ovf_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic g_start(input int ch);
    return ch == 0 ? tx_start_o : rx_start_o;
  endfunction
  function automatic logic [7:0] g_page(input int ch);
    return ch == 0 ? tx_page_o : rx_page_o;
  endfunction
  function automatic logic g_evt(input int ch);
    return ch == 0 ? tx_evt_o : rx_evt_o;
  endfunction
  function automatic logic g_ok(input int ch);
    return ch == 0 ? tx_ack_o : rx_ok_o;
  endfunction
  function automatic logic g_idle(input int ch);
    return ch == 0 ? tx_avail_o : rx_inhib_o;
  endfunction

  task automatic s_cmd(input int ch, input logic v, input logic [7:0] p);
    if (ch == 0) begin tx_cmd_i = v; tx_page_i = p; end
    else begin rx_cmd_i = v; rx_page_i = p; end
  endtask
  task automatic s_done(input int ch, input logic v, input logic ok);
    if (ch == 0) begin tx_done_i = v; tx_ack_i = ok; end
    else begin rx_done_i = v; rx_ok_i = ok; end
  endtask
  task automatic s_clr(input int ch, input logic v);
    if (ch == 0) tx_clr_i = v; else rx_clr_i = v;
  endtask
  task automatic s_mask(input int ch, input logic v);
    if (ch == 0) tx_mask_i = v; else rx_mask_i = v;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 tx_avail", tx_avail_o, 1);
    chk("R1 rx_inhib", rx_inhib_o, 1);
    chk("R1 evts", {tx_evt_o, rx_evt_o, tx_ack_o, rx_ok_o}, 0);
    chk("R1 irq/ovf", {irq_o, ovf_o}, 0);
    chk("R1 starts", {tx_start_o, rx_start_o}, 0);

    // R9 done while idle
    s_done(0, 1, 1); s_done(1, 1, 1);
    cyc();
    s_done(0, 0, 0); s_done(1, 0, 0);
    chk("R9 no evt", {tx_evt_o, rx_evt_o}, 0);

    // table walk on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 6; v++) begin
        s_mask(ch, VEC[v].mask);
        s_cmd(ch, 1, VEC[v].page);
        cyc();
        s_cmd(ch, 0, 8'h00);
        chk("R2 idle drops", g_idle(ch), 0);
        chk("R2 no early start", g_start(ch), 0);
        cyc();
        chk("R2 start", g_start(ch), 1);
        chk("R2 page", g_page(ch), VEC[v].page);
        cyc();
        chk("R2 pulse width", g_start(ch), 0);
        s_done(ch, 1, VEC[v].ok);
        cyc();
        s_done(ch, 0, 0);
        chk("R4 evt", g_evt(ch), 1);
        chk("R4 ok bit", g_ok(ch), VEC[v].exp_ok);
        chk("R4 idle back", g_idle(ch), 1);
        chk("R7 irq", irq_o, VEC[v].exp_irq);
        s_clr(ch, 1);
        cyc();
        s_clr(ch, 0);
        chk("R5 retired", g_evt(ch), 0);
        chk("R7 irq off", irq_o, 0);
        s_mask(ch, 0);
      end
    end

    // R5 clear with nothing queued, then two commands still fit
    tx_clr_i = 1;
    cyc();
    tx_clr_i = 0;
    chk("R5 empty clr evt", tx_evt_o, 0);
    chk("R5 empty clr idle", tx_avail_o, 1);

    // R3 chaining: second command while first runs
    s_cmd(0, 1, 8'hA1);
    cyc();
    s_cmd(0, 1, 8'hB2);
    cyc();
    s_cmd(0, 0, 8'h00);
    chk("R3 first start", tx_start_o, 1);
    chk("R3 first page", tx_page_o, 8'hA1);
    chk("R5 no underflow ovf", ovf_o, 0);
    cyc();
    s_done(0, 1, 1);
    cyc();
    s_done(0, 0, 0);
    chk("R3 not same cycle", tx_start_o, 0);
    chk("R3 evt queued", tx_evt_o, 1);
    chk("R4 still busy", tx_avail_o, 0);
    cyc();
    chk("R3 chained start", tx_start_o, 1);
    chk("R3 chained page", tx_page_o, 8'hB2);
    cyc();
    s_done(0, 1, 0);
    cyc();
    s_done(0, 0, 0);
    chk("R4 idle after both", tx_avail_o, 1);
    chk("R5 oldest ok", tx_ack_o, 1);
    tx_clr_i = 1;
    cyc();
    tx_clr_i = 0;
    chk("R5 next evt", tx_evt_o, 1);
    chk("R5 next ok", tx_ack_o, 0);
    tx_clr_i = 1;
    cyc();
    tx_clr_i = 0;
    chk("R5 drained", tx_evt_o, 0);
    chk("R6 no ovf yet", ovf_o, 0);

    // R8 interleave: both kinds together, rx finishes first
    rx_mask_i = 1;
    s_cmd(0, 1, 8'h31); s_cmd(1, 1, 8'h42);
    cyc();
    s_cmd(0, 0, 8'h00); s_cmd(1, 0, 8'h00);
    cyc();
    chk("R8 both start", {tx_start_o, rx_start_o}, 2'b11);
    chk("R8 pages", {tx_page_o, rx_page_o}, 16'h3142);
    s_done(1, 1, 1);
    cyc();
    s_done(1, 0, 0);
    chk("R8 rx evt only", {tx_evt_o, rx_evt_o}, 2'b01);
    chk("R8 live flags", {tx_avail_o, rx_inhib_o}, 2'b01);
    chk("R7 rx irq", irq_o, 1);
    rx_mask_i = 0;
    s_done(0, 1, 0);
    cyc();
    s_done(0, 0, 0);
    chk("R7 masked off", irq_o, 0);
    chk("R7 evt unmasked", {tx_evt_o, rx_evt_o, rx_ok_o}, 3'b111);
    s_clr(0, 1); s_clr(1, 1);
    cyc();
    s_clr(0, 0); s_clr(1, 0);
    chk("R8 both cleared", {tx_evt_o, rx_evt_o}, 0);

    // R6 overflow: slots held by uncleared events
    s_cmd(1, 1, 8'h01);
    cyc();
    s_cmd(1, 1, 8'h02);
    cyc();
    s_cmd(1, 1, 8'h03);
    cyc();
    s_cmd(1, 0, 8'h00);
    chk("R6 ovf set", ovf_o, 1);
    s_done(1, 1, 1);
    cyc();
    s_done(1, 0, 0);
    cyc();
    chk("R6 second page", rx_page_o, 8'h02);
    s_done(1, 1, 1);
    cyc();
    s_done(1, 0, 0);
    s_cmd(1, 1, 8'h04);
    cyc();
    s_cmd(1, 0, 8'h00);
    for (int k = 0; k < 3; k++) begin
      chk("R6 dropped never starts", rx_start_o, 0);
      chk("R6 idle", rx_inhib_o, 1);
      cyc();
    end
    s_clr(1, 1);
    cyc();
    cyc();
    s_clr(1, 0);
    chk("R6 ovf sticky", ovf_o, 1);
    chk("R6 slots free", rx_evt_o, 0);
    s_cmd(1, 1, 8'h05);
    cyc();
    s_cmd(1, 0, 8'h00);
    cyc();
    chk("R6 new start", rx_start_o, 1);
    chk("R6 new page", rx_page_o, 8'h05);
    s_done(1, 1, 0);
    cyc();
    s_done(1, 0, 0);

    rst_ni = 1'b0;
    cyc();
    rst_ni = 1'b1;
    cyc();
    chk("R6 ovf reset", ovf_o, 0);
    chk("R1 evt reset", rx_evt_o, 0);

    finish_run();
  end
endmodule